// File: doc/BRIEF.md
# Power-Fail Shutdown and Reset Sequencer

This block turns a single supply-health input into an ordered set of active-low control lines for a controller board: a CPU interrupt, a CPU stop line, the system reset, and a separate reset for a keyboard/clock peripheral controller. When the supply reports a failure while the system is running, the block first pulls the interrupt low so software can save its state. After a programmable delay it pulls the stop line low. One cycle later it pulls both resets low.

When the supply recovers, every line stays asserted until the good indication has held without a break for a minimum interval. That interval is built from a clock divider times a tick count, and by default it is 10 ms at 100 MHz. Any drop during the interval restarts the count. After the interval the block releases the stop line, the interrupt and the peripheral reset. It then sends a burst of eight clock pulses on the peripheral link and only after that releases the system reset. A supply failure during this burst does not wait for the startup to finish: the block goes straight into the shutdown order at its interrupt step, and the system reset stays low.

Top module: `pwr_fail_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `irq_n`, `stop_n`, `sysrst_n` and `perrst_n` are all low and `per_sclk` is low, whatever `pwr_good` does.
- R2: From the fully asserted state, every output stays low until `pwr_good` has been sampled high on TICK_DIV*MIN_TICKS consecutive clock edges. If `pwr_good` is sampled low during that window, the block returns to the fully asserted state and the count starts again from zero.
- R3: On the clock edge that ends the interval, `stop_n`, `irq_n` and `perrst_n` go high together while `sysrst_n` stays low.
- R4: The startup burst lasts 2*SCLK_HALF*PULSES cycles. Counting cycle b from 0 at the release of R3, `per_sclk` equals (b / SCLK_HALF) mod 2. This gives exactly PULSES (8 by default) high pulses. `per_sclk` is low at all other times.
- R5: `sysrst_n` goes high on the clock edge that ends the burst, which puts all four control lines high.
- R6: From the running state, if `pwr_good` is sampled low, `irq_n` falls on that edge and `stop_n` and both resets stay high. `stop_n` falls STOP_DLY cycles later. On the next edge `sysrst_n` and `perrst_n` fall.
- R7: If `pwr_good` is sampled low during the burst, the burst stops and the R6 order starts at its interrupt step on that edge. `sysrst_n` stays low throughout, and `perrst_n` stays high until the final step.
- R8: If `pwr_good` is sampled low during the minimum interval, all outputs are already low and stay low, and the interval restarts from zero.
- R9: Once a shutdown has begun, `pwr_good` returning high does not shorten or alter it. A new startup interval begins only after both resets are low.
- R10: The peripheral reset is a separate output. It is released one step before the system reset, and the two are never merged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-health indication, high when the supply is good |
| irq_n | output | 1 | Active-low power-fail interrupt to the CPU |
| stop_n | output | 1 | Active-low CPU stop line |
| sysrst_n | output | 1 | Active-low system reset |
| perrst_n | output | 1 | Active-low reset for the peripheral controller |
| per_sclk | output | 1 | Serial clock burst on the peripheral link |

## Verification
A wrong state register or step counter shows up at the ports within one cycle as an illegal combination of the four lines. Examples are `stop_n` falling while `irq_n` is still high, or `sysrst_n` rising before `perrst_n`. A miscounted interval or burst shows up as the edge of `stop_n` or `sysrst_n` landing one or more cycles off its computed position. A miscounted burst also shows up as a pulse count that is not eight. The bench drops the supply at every cycle of a startup and compares each output, cycle by cycle, against arithmetic expectations. This means an abort path that starts from the wrong step shows up on the first cycle after the drop.

// File: rtl/pfseq_pkg.sv
package pfseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_BURST,
        ST_RUN,
        ST_SD_IRQ,
        ST_SD_STOP
    } seq_state_e;

    typedef struct packed {
        logic irq_n;
        logic stop_n;
        logic sysrst_n;
        logic perrst_n;
    } ctl_t;

    localparam ctl_t CTL_ASSERTED = '0;

    // Control lines for a state; the system reset keeps its previous level
    // while shutting down, so an aborted startup never releases it.
    function automatic ctl_t ctl_for(seq_state_e s, logic sys_prev);
        ctl_t c;
        c = CTL_ASSERTED;
        case (s)
            ST_BURST:   begin c.irq_n = 1'b1; c.stop_n = 1'b1; c.perrst_n = 1'b1; end
            ST_RUN:     c = '1;
            ST_SD_IRQ:  begin c.stop_n = 1'b1; c.perrst_n = 1'b1; c.sysrst_n = sys_prev; end
            ST_SD_STOP: begin c.perrst_n = 1'b1; c.sysrst_n = sys_prev; end
            default:    c = CTL_ASSERTED;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfseq_span.sv
module pfseq_span #(
    parameter int DIV   = 1000,
    parameter int COUNT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int DW = (DIV   > 1) ? $clog2(DIV)   : 1;
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [DW-1:0] div_q;
    logic [CW-1:0] cnt_q;
    logic          div_end;
    logic          cnt_end;

    assign div_end = (div_q == DW'(DIV - 1));
    assign cnt_end = (cnt_q == CW'(COUNT - 1));
    assign done    = en && div_end && cnt_end;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_end) begin
            div_q <= '0;
            cnt_q <= cnt_end ? '0 : cnt_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    a_r2_span_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !en |=> (div_q == '0 && cnt_q == '0));
endmodule

// File: rtl/pfseq_burst.sv
module pfseq_burst #(
    parameter int HALF   = 50,
    parameter int PULSES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic done
);
    localparam int HW = (HALF   > 1) ? $clog2(HALF)   : 1;
    localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;

    logic [HW-1:0] half_q;
    logic [PW-1:0] pulse_q;
    logic          phase_q;
    logic          half_end;

    assign half_end = (half_q == HW'(HALF - 1));
    assign sclk     = phase_q;
    assign done     = en && half_end && phase_q && (pulse_q == PW'(PULSES - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            half_q  <= '0;
            pulse_q <= '0;
            phase_q <= 1'b0;
        end else if (half_end) begin
            half_q  <= '0;
            phase_q <= ~phase_q;
            if (phase_q) pulse_q <= pulse_q + 1'b1;
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    a_r4_burst_starts_low: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> !phase_q);
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
    import pfseq_pkg::*;
#(
    parameter int TICK_DIV  = 1000,
    parameter int MIN_TICKS = 1000,
    parameter int SCLK_HALF = 50,
    parameter int PULSES    = 8,
    parameter int STOP_DLY  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    output logic irq_n,
    output logic stop_n,
    output logic sysrst_n,
    output logic perrst_n,
    output logic per_sclk
);
    localparam int MIN_CYC = TICK_DIV * MIN_TICKS;
    localparam int RW      = $clog2(MIN_CYC + 2) + 1;

    seq_state_e st_q, st_d;
    ctl_t       ctl_q;
    logic       wait_done, burst_done, dly_done, sclk_raw;

    pfseq_span #(.DIV(TICK_DIV), .COUNT(MIN_TICKS)) i_interval (
        .clk(clk), .rst(rst), .en(st_q == ST_WAIT), .done(wait_done)
    );

    pfseq_span #(.DIV(STOP_DLY), .COUNT(1)) i_stop_delay (
        .clk(clk), .rst(rst), .en(st_q == ST_SD_IRQ), .done(dly_done)
    );

    pfseq_burst #(.HALF(SCLK_HALF), .PULSES(PULSES)) i_burst (
        .clk(clk), .rst(rst), .en(st_q == ST_BURST), .sclk(sclk_raw), .done(burst_done)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF:     if (pwr_good) st_d = ST_WAIT;
            ST_WAIT:    if (!pwr_good) st_d = ST_OFF;
                        else if (wait_done) st_d = ST_BURST;
            ST_BURST:   if (!pwr_good) st_d = ST_SD_IRQ;
                        else if (burst_done) st_d = ST_RUN;
            ST_RUN:     if (!pwr_good) st_d = ST_SD_IRQ;
            ST_SD_IRQ:  if (dly_done) st_d = ST_SD_STOP;
            ST_SD_STOP: st_d = ST_OFF;
            default:    st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_OFF;
            ctl_q <= CTL_ASSERTED;
        end else begin
            st_q  <= st_d;
            ctl_q <= ctl_for(st_d, ctl_q.sysrst_n);
        end
    end

    assign irq_n    = ctl_q.irq_n;
    assign stop_n   = ctl_q.stop_n;
    assign sysrst_n = ctl_q.sysrst_n;
    assign perrst_n = ctl_q.perrst_n;
    assign per_sclk = sclk_raw && (st_q == ST_BURST);

    // Consecutive good-supply edges, used only by the interval check.
    logic [RW-1:0] good_run_q;
    always_ff @(posedge clk) begin
        if (rst || !pwr_good) good_run_q <= '0;
        else if (good_run_q <= RW'(MIN_CYC)) good_run_q <= good_run_q + 1'b1;
    end

    a_r1_reset_asserted: assert property (@(posedge clk)
        rst |=> (!irq_n && !stop_n && !sysrst_n && !perrst_n && !per_sclk));
    a_r2_min_interval: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_n) |-> (good_run_q >= RW'(MIN_CYC)));
    a_r3_sys_held_on_stop_release: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_n) |-> (!sysrst_n && irq_n && perrst_n));
    a_r4_sclk_window: assert property (@(posedge clk) disable iff (rst)
        per_sclk |-> (stop_n && !sysrst_n));
    a_r5_sys_release_last: assert property (@(posedge clk) disable iff (rst)
        $rose(sysrst_n) |-> (stop_n && irq_n && perrst_n && !per_sclk));
    a_r6_stop_after_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> !irq_n);
    a_r6_reset_after_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(sysrst_n) |-> (!stop_n && $past(!stop_n)));
    a_r6_run_fail_irq_first: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !pwr_good) |=> (!irq_n && stop_n && sysrst_n && perrst_n));
    a_r7_burst_abort: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BURST && !pwr_good) |=> (!irq_n && stop_n && !sysrst_n && !per_sclk));
    a_r8_wait_abort: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && !pwr_good) |=> (st_q == ST_OFF && !stop_n && !perrst_n));
    a_r10_per_before_sys: assert property (@(posedge clk) disable iff (rst)
        $rose(perrst_n) |-> !sysrst_n);
endmodule

// File: tb/test_pwr_fail_seq.sv
`timescale 1ns/1ps
module test_pwr_fail_seq;
    localparam int TD = 3;
    localparam int MT = 4;
    localparam int H  = 2;
    localparam int P  = 8;
    localparam int SD = 5;
    localparam int D  = TD * MT;
    localparam int B  = 2 * H * P;

    // Output vector order: {irq_n, stop_n, sysrst_n, perrst_n, per_sclk}
    localparam logic [4:0] V_OFF   = 5'b00000;
    localparam logic [4:0] V_BURST = 5'b11010;
    localparam logic [4:0] V_RUN   = 5'b11110;
    localparam logic [4:0] V_SDI_R = 5'b01110;
    localparam logic [4:0] V_SDS_R = 5'b00110;
    localparam logic [4:0] V_SDI_B = 5'b01010;
    localparam logic [4:0] V_SDS_B = 5'b00010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0;
    logic irq_n, stop_n, sysrst_n, perrst_n, per_sclk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwr_fail_seq #(.TICK_DIV(TD), .MIN_TICKS(MT), .SCLK_HALF(H), .PULSES(P), .STOP_DLY(SD))
    i_pwr_fail_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good),
        .irq_n(irq_n), .stop_n(stop_n), .sysrst_n(sysrst_n),
        .perrst_n(perrst_n), .per_sclk(per_sclk)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [4:0] exp);
        logic [4:0] act;
        act = {irq_n, stop_n, sysrst_n, perrst_n, per_sclk};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Full startup from the asserted state, checking every cycle.
    task automatic startup();
        int rises;
        logic prev;
        pwr_good = 1'b1;
        for (int i = 1; i <= D; i++) begin
            tick();
            chk("R2 interval hold", V_OFF);
        end
        rises = 0;
        prev = 1'b0;
        for (int b = 0; b < B; b++) begin
            tick();
            chk(b == 0 ? "R3 stop release" : "R4 burst",
                V_BURST | 5'((b / H) % 2));
            if (per_sclk && !prev) rises++;
            prev = per_sclk;
        end
        checks++;
        if (rises != P) begin
            fails++;
            $display("FAIL R4 pulse count: actual %0d expected %0d", rises, P);
        end
        tick();
        chk("R5 system release", V_RUN);
    endtask

    task automatic shutdown(logic [4:0] v_irq, logic [4:0] v_stop, string req);
        pwr_good = 1'b0;
        for (int i = 1; i <= SD; i++) begin
            tick();
            chk(req, v_irq);
        end
        tick();
        chk(req, v_stop);
        tick();
        chk(req, V_OFF);
    endtask

    initial begin
        // R1: reset holds everything asserted even with a good supply
        pwr_good = 1'b1;
        repeat (3) tick();
        chk("R1 reset", V_OFF);
        pwr_good = 1'b0;
        rst = 1'b0;
        tick();
        chk("R1 after reset", V_OFF);
        repeat (3) tick();
        chk("R1 idle no supply", V_OFF);

        // Normal startup and shutdown (R2..R6, R10)
        startup();
        repeat (4) tick();
        chk("R5 running", V_RUN);
        shutdown(V_SDI_R, V_SDS_R, "R6 shutdown order");

        // R2 restart: drop during interval, full count again
        pwr_good = 1'b1;
        repeat (5) tick();
        pwr_good = 1'b0;
        tick();
        chk("R2 drop restarts", V_OFF);
        startup();
        shutdown(V_SDI_R, V_SDS_R, "R6 second shutdown");

        // Sweep the drop point over every cycle of a startup (R6, R7, R8)
        for (int k = 1; k <= D + B + 1; k++) begin
            pwr_good = 1'b1;
            repeat (k) tick();
            if (k <= D) begin
                pwr_good = 1'b0;
                tick();
                chk("R8 abort in interval", V_OFF);
                tick();
                chk("R8 stays asserted", V_OFF);
            end else if (k <= D + B) begin
                shutdown(V_SDI_B, V_SDS_B, "R7 abort in burst");
            end else begin
                shutdown(V_SDI_R, V_SDS_R, "R6 abort from run");
            end
        end

        // R9: supply returns mid-shutdown; order completes, then fresh interval
        startup();
        pwr_good = 1'b0;
        tick();
        chk("R9 irq first", V_SDI_R);
        pwr_good = 1'b1;
        for (int i = 2; i <= SD; i++) begin
            tick();
            chk("R9 shutdown continues", V_SDI_R);
        end
        tick();
        chk("R9 stop step", V_SDS_R);
        tick();
        chk("R9 resets low", V_OFF);
        for (int i = 1; i <= D; i++) begin
            tick();
            chk("R9 new interval", V_OFF);
        end
        tick();
        chk("R9 R10 per reset before system", V_BURST);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule